// File: doc/BRIEF.md
# Serial/Parallel FIFO Input Register

This block is the write-side front end of a nibble-wide FIFO slice. A word enters either all at once through a four-bit parallel port, or one bit at a time through a serial data pin that is clocked on the falling edge of a serial strobe. When all four bits are present, the block drops an active-LOW full flag. On a transfer request it hands the word to the storage stack behind it, as soon as the top stack location is free. It then returns to its empty state so that the next word can be taken.

Completion is detected with a travelling token. At initialization a single 1 is placed in the top data bit. Each serial shift pushes that token one place further down the chain. When the token reaches an extra marker bit, the word is complete. The same marker is set directly by a parallel load.

A request flag records that a push has taken place, so a transfer request that stays asserted cannot push the same word twice. Re-initialization waits while the parallel load strobe is still HIGH. Slices can be chained so that each one waits for the previous one: a slice that was not a master at reset re-arms only after its serial enable input, fed from the previous slice's full flag, goes LOW. All strobes are synchronous samples on one system clock.

Top module: `sp_fifo_inreg`

## Requirements
- R1: A clock edge with `rst_n` LOW initializes the register: `full_n` goes HIGH, any pending request is dropped, the top data bit is set to 1 and the other data bits and the marker are cleared. The same edge records master mode when `ser_en_n` is LOW and slave mode when it is HIGH.
- R2: `full_n` is the inverse of the marker bit. It is HIGH after initialization and LOW exactly when a complete word is held.
- R3: On every clock edge with `load` HIGH, `par_in` is captured and the marker is set, so `full_n` reads LOW on the following cycle.
- R4: A serial bit is shifted in when `ser_clk` was HIGH on the previous edge and is LOW on this edge, provided `ser_en_n` and `load` are both LOW. The chain runs `ser_in`, then bit 3, bit 2, bit 1, bit 0, then the marker, so the first serial bit ends in `push_data[0]` and the fourth in `push_data[3]`. While `ser_en_n` is HIGH, falling edges do nothing.
- R5: After the fourth shift `full_n` is LOW, and further falling edges of `ser_clk` leave the held word unchanged until the register is re-initialized.
- R6: `push` is HIGH for one cycle when `xfer_n` is LOW, `top_empty` is HIGH, a complete word is held and that word has not already been pushed. During that cycle `push_data` carries the word. While `top_empty` is LOW, no push occurs.
- R7: While `load` is HIGH after a push, re-initialization is deferred and the word is not pushed again even though `xfer_n` stays LOW. On the first edge with `load` LOW, the register re-initializes.
- R8: A master slice re-initializes on the edge of its push. A slave slice keeps `full_n` LOW after its push, without pushing again, until the first edge on which `ser_en_n` is LOW.
- R9: With `xfer_n` tied to `full_n` and `top_empty` HIGH, each loaded word is pushed exactly once and the register re-arms on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-LOW master reset |
| par_in | input | 4 | Parallel data word |
| ser_in | input | 1 | Serial data bit |
| load | input | 1 | Parallel load strobe, active HIGH |
| ser_clk | input | 1 | Serial strobe, acts on its falling edge |
| ser_en_n | input | 1 | Serial enable and chain input, active LOW |
| xfer_n | input | 1 | Transfer-to-stack request, active LOW |
| top_empty | input | 1 | Top stack location is free |
| push | output | 1 | One-cycle write strobe to the stack |
| push_data | output | 4 | Word presented to the stack |
| full_n | output | 1 | Word complete when LOW |

## Verification
The bench holds `xfer_n` LOW across many cycles while `load` stays HIGH, and while a slave waits for its enable. A design whose request flag is wrong would push the same word again in every cycle. Extra serial edges after the fourth are sent to show that a design that does not gate the shift with the marker would corrupt the word. A reset in the middle of a word, serial edges sent with the enable HIGH, and a busy stack top check that partial state is cleared and that no push leaks out. With the full flag looped back to the transfer request, a design that re-armed before the push had been recorded, or that missed the recording, would give zero pushes or many instead of exactly one.

// File: rtl/sp_fifo_inreg.sv
module sp_fifo_inreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  input  logic         load,
  input  logic         ser_clk,
  input  logic         ser_en_n,
  input  logic         xfer_n,
  input  logic         top_empty,
  output logic         push,
  output logic [W-1:0] push_data,
  output logic         full_n
);
  localparam logic [W-1:0] INIT = W'(1) << (W - 1);

  logic [W-1:0] word;
  logic mark, req, master, sc_q;

  wire sc_fall  = sc_q & ~ser_clk;
  wire shift_en = sc_fall & ~ser_en_n & ~load & ~mark;
  wire may_init = ~load & (master | ~ser_en_n);
  wire do_init  = (push | req) & may_init;

  assign push      = mark & ~req & ~xfer_n & top_empty;
  assign push_data = word;
  assign full_n    = ~mark;

  always_ff @(posedge clk) begin
    sc_q <= ser_clk;
    if (!rst_n) begin
      word   <= INIT;
      mark   <= 1'b0;
      req    <= 1'b0;
      master <= ~ser_en_n;
    end else if (do_init) begin
      word <= INIT;
      mark <= 1'b0;
      req  <= 1'b0;
    end else begin
      if (push) req <= 1'b1;
      if (load) begin
        word <= par_in;
        mark <= 1'b1;
      end else if (shift_en) begin
        word <= {ser_in, word[W-1:1]};
        mark <= word[0];
      end
    end
  end
endmodule

// File: rtl/sp_fifo_inreg_chk.sv
module sp_fifo_inreg_chk (
  input logic clk,
  input logic rst_n,
  input logic load,
  input logic ser_clk,
  input logic top_empty,
  input logic push,
  input logic full_n
);
  a_r3_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !full_n);

  a_r2_full_only_by_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_n) |-> ($past(load) || ($past(ser_clk, 2) && !$past(ser_clk))));

  a_r7_single_push: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

  a_r6_top_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !top_empty |-> !push);
endmodule

bind sp_fifo_inreg sp_fifo_inreg_chk chk_i (.*);

// File: tb/sp_fifo_inreg_tb_top.sv
module sp_fifo_inreg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] par_in = '0;
  logic ser_in = 1'b0, load = 1'b0, ser_clk = 1'b0, ser_en_n = 1'b0;
  logic xfer_drv = 1'b1, auto_x = 1'b0, top_empty = 1'b0;
  logic xfer_n, push, full_n;
  logic [3:0] push_data;
  int errors = 0, checks = 0, npush = 0;
  logic [3:0] last_data = '0;

  assign xfer_n = auto_x ? full_n : xfer_drv;

  always #4 clk = ~clk;

  sp_fifo_inreg dut_i (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in), .load(load),
    .ser_clk(ser_clk), .ser_en_n(ser_en_n), .xfer_n(xfer_n), .top_empty(top_empty),
    .push(push), .push_data(push_data), .full_n(full_n));

  always @(posedge clk) if (push) begin npush++; last_data = push_data; end

  // bit 4 selects serial entry, bits 3:0 are the word
  localparam logic [4:0] VEC [8] = '{5'h0A, 5'h15, 5'h00, 5'h1F, 5'h0F, 5'h10, 5'h16, 5'h19};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic en_n);
    @(negedge clk); rst_n = 1'b0; ser_en_n = en_n;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic pload(input logic [3:0] d);
    @(negedge clk); load = 1'b1; par_in = d;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic shift(input logic b);
    @(negedge clk); ser_in = b; ser_clk = 1'b1;
    @(negedge clk); ser_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_chk(input logic [3:0] exp, input string req);
    @(negedge clk); top_empty = 1'b1; xfer_drv = 1'b0;
    #1 chk(push === 1'b1, req, push, 1);
    chk(push_data === exp, req, push_data, exp);
    @(negedge clk); xfer_drv = 1'b1; top_empty = 1'b0;
    #1 chk(full_n === 1'b1, "R8 master re-arms", full_n, 1);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    do_reset(1'b0);
    #1 chk(full_n === 1'b1, "R1 reset full_n", full_n, 1);
    chk(push === 1'b0, "R1 reset push", push, 0);

    for (int i = 0; i < 8; i++) begin
      logic [3:0] d;
      d = VEC[i][3:0];
      if (VEC[i][4]) for (int k = 0; k < 4; k++) shift(d[k]);
      else pload(d);
      #1 chk(full_n === 1'b0, VEC[i][4] ? "R4 serial word full" : "R3 load full", full_n, 0);
      push_chk(d, VEC[i][4] ? "R4 serial push" : "R6 parallel push");
    end

    // R5: edges after the fourth are ignored
    shift(1); shift(0); shift(1); shift(1);
    shift(0); shift(0);
    #1 chk(full_n === 1'b0, "R5 still full", full_n, 0);
    push_chk(4'hD, "R5 word kept");

    // R4: enable HIGH blocks shifting
    ser_en_n = 1'b1;
    for (int k = 0; k < 4; k++) shift(1);
    #1 chk(full_n === 1'b1, "R4 enable high ignored", full_n, 1);
    ser_en_n = 1'b0;

    // R6: busy stack top
    pload(4'h9);
    base = npush;
    @(negedge clk); xfer_drv = 1'b0; top_empty = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk(npush == base, "R6 busy top no push", npush - base, 0);
    chk(full_n === 1'b0, "R6 busy top word held", full_n, 0);
    xfer_drv = 1'b1;
    push_chk(4'h9, "R6 push after top frees");

    // R7: deferral while load HIGH
    base = npush;
    @(negedge clk); load = 1'b1; par_in = 4'h3; top_empty = 1'b1; xfer_drv = 1'b0;
    repeat (5) @(negedge clk);
    #1 chk(npush - base == 1, "R7 one push under load", npush - base, 1);
    chk(full_n === 1'b0, "R7 re-init deferred", full_n, 0);
    chk(last_data === 4'h3, "R7 pushed data", last_data, 3);
    load = 1'b0;
    @(negedge clk);
    #1 chk(full_n === 1'b1, "R7 re-init after load low", full_n, 1);
    chk(npush - base == 1, "R7 no second push", npush - base, 1);
    xfer_drv = 1'b1; top_empty = 1'b0;

    // R1: reset mid-word
    shift(1); shift(1);
    do_reset(1'b0);
    #1 chk(full_n === 1'b1, "R1 mid-word reset", full_n, 1);
    shift(0); shift(1); shift(1); shift(0);
    push_chk(4'h6, "R1 clean word after reset");

    // R8: slave waits for enable
    do_reset(1'b1);
    pload(4'h5);
    base = npush;
    @(negedge clk); top_empty = 1'b1; xfer_drv = 1'b0;
    repeat (4) @(negedge clk);
    #1 chk(npush - base == 1, "R8 slave single push", npush - base, 1);
    chk(full_n === 1'b0, "R8 slave waits", full_n, 0);
    ser_en_n = 1'b0;
    @(negedge clk);
    #1 chk(full_n === 1'b1, "R8 slave re-arms on enable", full_n, 1);
    chk(npush - base == 1, "R8 no extra push", npush - base, 1);
    xfer_drv = 1'b1; top_empty = 1'b0;
    do_reset(1'b0);

    // R9: automatic write-through
    auto_x = 1'b1; top_empty = 1'b1;
    base = npush;
    pload(4'hC);
    repeat (6) @(negedge clk);
    #1 chk(npush - base == 1, "R9 exactly one push", npush - base, 1);
    chk(last_data === 4'hC, "R9 pushed data", last_data, 12);
    chk(full_n === 1'b1, "R9 re-armed", full_n, 1);
    auto_x = 1'b0; top_empty = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule